// File: doc/BRIEF.md
# Multi-register transfer sequencer

This block moves a group of registers between a register file and word-addressed memory with a single command. The command carries a base address, a 16-bit selection mask (one bit per register), a direction flag (load or store), a writeback flag and a one-cycle start strobe. The block takes the selected registers one at a time, from the lowest index to the highest. For each one it issues a memory request at a word address, and that address rises by one word per transfer, starting at the base.

In the store direction, the word written to memory is read from the register file through a combinational read port. In the load direction, each returned word is written into its register in the cycle the memory accepts the request. Register 15 serves as the program counter. Loading it does not write the register file. Instead, after the last transfer the block presents a branch request whose target is the loaded word with its two low bits cleared, which lets a restore sequence end in a return. When writeback is requested, the advanced base (base plus four bytes per selected register) is presented as the command finishes.

Top module: `multireg_xfer`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o, rf_we_o, wb_valid_o and br_valid_o are all low.
- R2: A start_i seen while idle is accepted. From the next cycle, mem_req_o is high and rf_raddr_o/rf_waddr_o carry the selected register indices in ascending order, one index per accepted transfer.
- R3: The first request address equals base_i, and each later request address is 4 higher than the previous accepted one.
- R4: While mem_rdy_i is low, a pending request stays up with the same address, index and direction.
- R5: done_o is high for exactly one cycle, the cycle after the last accepted transfer, and mem_req_o is low then. busy_o is high from the cycle after the start until that done cycle, and low in the cycle after it.
- R6: When wb_i was set, wb_valid_o is high in the done cycle with wb_data_o = base + 4 × (number of set mask bits). When wb_i was clear, wb_valid_o stays low.
- R7: For a load (load_i = 1), in each accepted-transfer cycle for a register other than 15, rf_we_o is high, with rf_waddr_o the register index and rf_wdata_o equal to mem_rdata_i.
- R8: For a store (load_i = 0), mem_we_o is high on every request, mem_wdata_o equals rf_rdata_i for the index on rf_raddr_o, and rf_we_o stays low.
- R9: A load that includes mask bit 15 does not write the register file for that transfer. br_valid_o is high in the done cycle, and br_target_o is the loaded word with bits 1:0 cleared. A store that includes bit 15 raises no branch.
- R10: An all-zero mask issues no request and pulses done_o in the cycle after the start. Any writeback value is then base_i unchanged.
- R11: A start_i seen while busy_o is high is ignored. The running command completes as first given, and no further request follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command strobe |
| base_i | input | 32 | Starting byte address |
| mask_i | input | 16 | Register selection, bit n selects register n |
| load_i | input | 1 | 1 = memory to registers, 0 = registers to memory |
| wb_i | input | 1 | Report the advanced base at completion |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory word address (byte units) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_rdy_i |
| mem_rdy_i | input | 1 | Memory accepts the request this cycle |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| wb_valid_o | output | 1 | Base writeback valid |
| wb_data_o | output | 32 | Advanced base value |
| br_valid_o | output | 1 | Branch request from a loaded program counter |
| br_target_o | output | 32 | Branch target, bits 1:0 zero |

## Verification
The request, its address and its register index appear one cycle after an accepted start. Register-file writes and store data respond in the same cycle as the memory ready, and the done, writeback and branch outputs appear one cycle after the final ready. An empty mask gives its done one cycle after the start. The bench sets every input on the falling clock edge and samples 1 ns later. It keeps a running beat count against the expected register list, so each sample is compared with the result due in that exact cycle. Commands are swept over many masks, both directions, both writeback settings and three memory stall patterns, with starts injected while busy.

// File: rtl/multireg_pkg.sv
package multireg_pkg;

    localparam int MRX_ADDR_W = 32;
    localparam int MRX_DATA_W = 32;
    localparam int MRX_NREG   = 16;

    typedef enum logic [1:0] {
        MRX_IDLE = 2'd0,
        MRX_XFER = 2'd1,
        MRX_FIN  = 2'd2
    } mrx_state_e;

    // Next state of the sequencer given the current state and events.
    function automatic mrx_state_e mrx_next(
        input mrx_state_e cur,
        input logic       start,
        input logic       empty,
        input logic       final_beat
    );
        mrx_state_e nxt;
        nxt = cur;
        case (cur)
            MRX_IDLE: if (start) nxt = empty ? MRX_FIN : MRX_XFER;
            MRX_XFER: if (final_beat) nxt = MRX_FIN;
            MRX_FIN:  nxt = MRX_IDLE;
            default:  nxt = MRX_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/mrx_pick.sv
module mrx_pick #(
    parameter int NREG = 16,
    localparam int IW = $clog2(NREG)
) (
    input  logic [NREG-1:0] rem,
    output logic [IW-1:0]   idx,
    output logic            last
);
    logic [NREG-1:0] low_oh;

    // Isolate the lowest set bit of the remaining selection.
    assign low_oh = rem & (~rem + NREG'(1));
    assign last   = ((rem & ~low_oh) == '0);

    for (genvar b = 0; b < IW; b++) begin : g_enc
        logic [NREG-1:0] sel;
        always_comb begin
            for (int i = 0; i < NREG; i++) begin
                sel[i] = 1'((i >> b) & 1);
            end
        end
        assign idx[b] = |(low_oh & sel);
    end
endmodule

// File: rtl/mrx_addr.sv
module mrx_addr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic [AW-1:0] base,
    input  logic          step_en,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load_en) begin
            addr <= base;
        end else if (step_en) begin
            addr <= addr + AW'(STEP);
        end
    end
endmodule

// File: rtl/mrx_ctrl.sv
module mrx_ctrl
    import multireg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic empty,
    input  logic beat,
    input  logic last,
    output logic accept,
    output logic in_xfer,
    output logic in_fin,
    output logic busy
);
    mrx_state_e state_q;

    assign accept  = start && (state_q == MRX_IDLE);
    assign in_xfer = (state_q == MRX_XFER);
    assign in_fin  = (state_q == MRX_FIN);
    assign busy    = (state_q != MRX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MRX_IDLE;
        end else begin
            state_q <= mrx_next(state_q, start, empty, beat && last);
        end
    end
endmodule

// File: rtl/multireg_xfer.sv
module multireg_xfer
    import multireg_pkg::*;
#(
    parameter int AW   = MRX_ADDR_W,
    parameter int DW   = MRX_DATA_W,
    parameter int NREG = MRX_NREG,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [AW-1:0]   base_i,
    input  logic [NREG-1:0] mask_i,
    input  logic            load_i,
    input  logic            wb_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    input  logic [DW-1:0]   mem_rdata_i,
    input  logic            mem_rdy_i,
    output logic [IW-1:0]   rf_raddr_o,
    input  logic [DW-1:0]   rf_rdata_i,
    output logic            rf_we_o,
    output logic [IW-1:0]   rf_waddr_o,
    output logic [DW-1:0]   rf_wdata_o,
    output logic            wb_valid_o,
    output logic [AW-1:0]   wb_data_o,
    output logic            br_valid_o,
    output logic [DW-1:0]   br_target_o
);
    localparam int WORD_BYTES = DW / 8;
    localparam int ALB        = $clog2(WORD_BYTES);
    localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

    typedef struct packed {
        logic [NREG-1:0] rem;
        logic            load;
        logic            wb;
    } cmd_t;

    cmd_t            cmd_q;
    logic            accept, in_xfer, in_fin, busy;
    logic            beat, last;
    logic [IW-1:0]   cur_idx;
    logic [AW-1:0]   addr_q;
    logic            br_q;
    logic [DW-1:0]   br_data_q;
    logic            cur_is_pc;

    mrx_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .empty   (mask_i == '0),
        .beat    (beat),
        .last    (last),
        .accept  (accept),
        .in_xfer (in_xfer),
        .in_fin  (in_fin),
        .busy    (busy)
    );

    mrx_pick #(.NREG(NREG)) u_pick (
        .rem  (cmd_q.rem),
        .idx  (cur_idx),
        .last (last)
    );

    mrx_addr #(.AW(AW), .STEP(WORD_BYTES)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .load_en (accept),
        .base    (base_i),
        .step_en (beat),
        .addr    (addr_q)
    );

    assign beat      = in_xfer && mem_rdy_i;
    assign cur_is_pc = (cur_idx == PC_IDX);

    // Command register: the remaining selection loses its lowest bit per beat.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q.rem  <= mask_i;
            cmd_q.load <= load_i;
            cmd_q.wb   <= wb_i;
        end else if (beat) begin
            cmd_q.rem[cur_idx] <= 1'b0;
        end
    end

    // Program-counter capture on a load beat for the top register.
    always_ff @(posedge clk) begin
        if (rst) begin
            br_q      <= 1'b0;
            br_data_q <= '0;
        end else if (accept) begin
            br_q <= 1'b0;
        end else if (beat && cmd_q.load && cur_is_pc) begin
            br_q      <= 1'b1;
            br_data_q <= {mem_rdata_i[DW-1:ALB], ALB'(0)};
        end
    end

    assign busy_o      = busy;
    assign done_o      = in_fin;
    assign mem_req_o   = in_xfer;
    assign mem_we_o    = in_xfer && !cmd_q.load;
    assign mem_addr_o  = addr_q;
    assign mem_wdata_o = rf_rdata_i;
    assign rf_raddr_o  = cur_idx;
    assign rf_waddr_o  = cur_idx;
    assign rf_wdata_o  = mem_rdata_i;
    assign rf_we_o     = beat && cmd_q.load && !cur_is_pc;
    assign wb_valid_o  = in_fin && cmd_q.wb;
    assign wb_data_o   = addr_q;
    assign br_valid_o  = in_fin && br_q;
    assign br_target_o = br_data_q;
endmodule

// File: rtl/mrx_chk.sv
module mrx_chk #(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG),
    localparam int ALB = $clog2(DW / 8)
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_rdy_i,
    input logic          rf_we_o,
    input logic [IW-1:0] rf_waddr_o,
    input logic [IW-1:0] rf_raddr_o,
    input logic          wb_valid_o,
    input logic          br_valid_o,
    input logic [DW-1:0] br_target_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_req_o && !done_o);                                  // R1
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o |=> busy_o);                                      // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_rdy_i |=> !mem_req_o || (mem_addr_o == $past(mem_addr_o) + AW'(DW / 8))); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(rf_raddr_o)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o);                                      // R5
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !mem_req_o);                                              // R5
    AST_WB_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> done_o);                                              // R6
    AST_RF_WRITE_BEAT: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> mem_req_o && mem_rdy_i && !mem_we_o);                    // R7
    AST_PC_NO_RF: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> rf_waddr_o != IW'(NREG - 1));                            // R9
    AST_BR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        br_valid_o |-> done_o && (br_target_o[ALB-1:0] == '0));              // R9
endmodule

bind multireg_xfer mrx_chk #(.AW(AW), .DW(DW), .NREG(NREG)) u_mrx_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdy_i   (mem_rdy_i),
    .rf_we_o     (rf_we_o),
    .rf_waddr_o  (rf_waddr_o),
    .rf_raddr_o  (rf_raddr_o),
    .wb_valid_o  (wb_valid_o),
    .br_valid_o  (br_valid_o),
    .br_target_o (br_target_o)
);

// File: tb/multireg_xfer_tb_top.sv
`timescale 1ns/1ps
module multireg_xfer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] mask_i = '0;
    logic        load_i = 1'b0;
    logic        wb_i = 1'b0;
    logic        busy_o, done_o, mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        mem_rdy_i = 1'b0;
    logic [3:0]  rf_raddr_o, rf_waddr_o;
    logic [31:0] rf_rdata_i, rf_wdata_o;
    logic        rf_we_o, wb_valid_o, br_valid_o;
    logic [31:0] wb_data_o, br_target_o;

    logic [31:0] mem_m [256];
    logic [31:0] rf_m  [16];
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    assign mem_rdata_i = mem_m[mem_addr_o[9:2]];
    assign rf_rdata_i  = rf_m[rf_raddr_o];

    multireg_xfer dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .mask_i(mask_i),
        .load_i(load_i), .wb_i(wb_i), .busy_o(busy_o), .done_o(done_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i),
        .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .wb_valid_o(wb_valid_o),
        .wb_data_o(wb_data_o), .br_valid_o(br_valid_o), .br_target_o(br_target_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic rdy_pat(input int mode, input int cyc);
        case (mode)
            0:       return 1'b1;
            1:       return cyc[0];
            default: return (cyc % 3) == 2;
        endcase
    endfunction

    task automatic run_cmd(input logic [31:0] base, input logic [15:0] mask,
                           input logic ld, input logic wbf, input int mode, input logic inj);
        int idxq[16];
        int n = 0;
        int k = 0;
        int cyc = 0;
        logic br_exp = 1'b0;
        logic [31:0] br_val = '0;
        logic [31:0] a;
        for (int i = 0; i < 16; i++) if (mask[i]) begin idxq[n] = i; n++; end
        @(negedge clk);
        base_i = base; mask_i = mask; load_i = ld; wb_i = wbf;
        start_i = 1'b1; mem_rdy_i = 1'b0;
        #1 chk("R2 idle before start", 32'(busy_o), 32'd0);
        forever begin
            @(negedge clk);
            start_i = inj && (cyc == 0 || k == n);
            if (inj) begin base_i = ~base; mask_i = ~mask; load_i = ~ld; wb_i = ~wbf; end
            mem_rdy_i = (k < n) ? rdy_pat(mode, cyc) : 1'b0;
            #1;
            if (k < n) begin
                a = base + 32'(4 * k);
                chk("R2 req", 32'(mem_req_o), 32'd1);
                chk("R5 busy", 32'(busy_o), 32'd1);
                chk("R5 no early done", 32'(done_o), 32'd0);
                chk("R3 addr", mem_addr_o, a);
                chk("R2 index order", 32'(rf_raddr_o), 32'(idxq[k]));
                chk("R8 dir", 32'(mem_we_o), 32'(!ld));
                if (mem_rdy_i) begin
                    if (ld) begin
                        if (idxq[k] == 15) begin
                            chk("R9 no rf write", 32'(rf_we_o), 32'd0);
                            br_exp = 1'b1;
                            br_val = mem_m[a[9:2]] & 32'hFFFF_FFFC;
                        end else begin
                            chk("R7 rf we", 32'(rf_we_o), 32'd1);
                            chk("R7 rf waddr", 32'(rf_waddr_o), 32'(idxq[k]));
                            chk("R7 rf wdata", rf_wdata_o, mem_m[a[9:2]]);
                            rf_m[idxq[k]] = mem_m[a[9:2]];
                        end
                    end else begin
                        chk("R8 store data", mem_wdata_o, rf_m[idxq[k]]);
                        chk("R8 no rf write", 32'(rf_we_o), 32'd0);
                        mem_m[a[9:2]] = rf_m[idxq[k]];
                    end
                    k++;
                end else begin
                    chk("R4 stall no rf write", 32'(rf_we_o), 32'd0);
                end
            end else begin
                chk(n == 0 ? "R10 done" : "R5 done", 32'(done_o), 32'd1);
                chk("R5 no req at done", 32'(mem_req_o), 32'd0);
                chk("R6 wb valid", 32'(wb_valid_o), 32'(wbf));
                if (wbf) chk(n == 0 ? "R10 wb base" : "R6 wb data", wb_data_o, base + 32'(4 * n));
                chk("R9 br valid", 32'(br_valid_o), 32'(br_exp));
                if (br_exp) chk("R9 br target", br_target_o, br_val);
                break;
            end
            cyc++;
        end
        @(negedge clk);
        start_i = 1'b0; mem_rdy_i = 1'b1;
        #1;
        chk("R5 idle after done", 32'(busy_o), 32'd0);
        chk("R11 no extra req", 32'(mem_req_o), 32'd0);
        chk("R5 done single", 32'(done_o), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] pats [9];
        pats[0] = 16'h0000; pats[1] = 16'h001E; pats[2] = 16'h8FF0; pats[3] = 16'h0FF0;
        pats[4] = 16'hFFFF; pats[5] = 16'h8000; pats[6] = 16'hAAAA; pats[7] = 16'h5555;
        pats[8] = 16'h8001;
        for (int i = 0; i < 256; i++) mem_m[i] = 32'h9E37_79B9 * 32'(i + 1);
        for (int i = 0; i < 16; i++)  rf_m[i]  = 32'hC000_0000 + 32'(i * 32'h0101_0107);
        repeat (3) @(negedge clk);
        #1;
        chk("R1 busy", 32'(busy_o), 32'd0);
        chk("R1 done", 32'(done_o), 32'd0);
        chk("R1 req", 32'(mem_req_o), 32'd0);
        chk("R1 outputs", {29'd0, rf_we_o, wb_valid_o, br_valid_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 after release", {30'd0, busy_o, mem_req_o}, 32'd0);
        for (int p = 0; p < 25; p++) begin
            logic [15:0] m;
            m = (p < 16) ? (16'h1 << p) : pats[p - 16];
            for (int ld = 0; ld < 2; ld++)
                for (int wbf = 0; wbf < 2; wbf++)
                    for (int mode = 0; mode < 3; mode++)
                        run_cmd(32'h4000_0100 + 32'(p * 8), m, ld[0], wbf[0], mode, mode == 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule